// File: doc/BRIEF.md
# Serial Boot Erase Command Responder

This block is the target-side byte sequencer that answers a host's request to erase the whole flash array and its protection bits while the device boots over a serial link. A receiver in front of it hands over one complete byte at a time with a valid strobe and a per-byte error flag. A transmitter behind it accepts acknowledge bytes under a busy signal. The first byte fixes the link flavour: asynchronous (UART) or clocked synchronous I/O. The block then walks a two-step command handshake, answering each byte, and finally starts an erase in a flash controller and reports the result.

Any failed step sends the host back to the start of the command sequence; the mode byte is not repeated. An unknown mode byte stops the block for good until reset. The flash controller is reached through a one-cycle request and a done/fail reply.

Top module: `boot_erase_responder`

## Requirements
- R1: The first byte after reset selects the mode: 0x86 selects UART mode and 0x30 selects I/O mode. That same byte is sent back as the acknowledge, and the block then waits for the command byte 0x40.
- R2: Any other first byte raises `halted` and sends no acknowledge. Every later byte is ignored, with no output, until reset.
- R3: While waiting for 0x40, a correct byte is acknowledged with 0x40. The block then waits for 0x54, and a correct 0x54 is acknowledged with 0x54.
- R4: A wrong, error-free command byte is answered with the upper nibble of the code expected at that step and a low nibble of 0x1 (0x41 at the first step, 0x51 at the second). The block then waits for 0x40 again.
- R5: In UART mode, a byte flagged with an error at either command step is answered with the expected code's upper nibble and a low nibble of 0x8 (0x48 or 0x58). The block then waits for 0x40.
- R6: In I/O mode, a byte flagged with an error gets no acknowledge, and the block waits for 0x40.
- R7: `eraseReq` is a one-cycle pulse. It is issued exactly once per accepted 0x54, in the cycle after the transmitter takes the 0x54 acknowledge.
- R8: While the erase is pending, received bytes are ignored. `eraseDone` produces 0x4F and `eraseFail` produces 0x4C. Fail wins when both are asserted together. The block then waits for 0x40.
- R9: `txValid` stays high and `txData` stays stable while `txBusy` is high. Exactly one byte is handed over per received byte that calls for an answer.
- R10: After synchronous reset, `txValid`, `eraseReq` and `halted` are low, and the block waits for the mode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxValid | input | 1 | One-cycle strobe: a received byte is present |
| rxData | input | 8 | Received byte |
| rxErr | input | 1 | Received byte carries a communication error |
| txBusy | input | 1 | Transmitter cannot take a byte this cycle |
| txValid | output | 1 | Acknowledge byte offered to the transmitter |
| txData | output | 8 | Acknowledge byte |
| eraseReq | output | 1 | One-cycle erase request to the flash controller |
| eraseDone | input | 1 | Erase finished successfully |
| eraseFail | input | 1 | Erase finished with failure |
| halted | output | 1 | Block stopped after an unknown mode byte |

## Verification
The bench builds the block with its default code parameters: mode bytes 0x86 and 0x30, command bytes 0x40 and 0x54, and result codes 0x4F and 0x4C. This makes the exact byte values of the nibble-built negative and error answers checkable. Random stall patterns on `txBusy` exercise the hold path on every answer. Seeded random command streams run in both modes. They mix correct, wrong and error-flagged bytes with done and fail outcomes, and junk bytes arrive during the erase wait.

// File: rtl/boot_erase_pkg.sv
package boot_erase_pkg;

  typedef enum logic [2:0] {
    ST_MODE, ST_CMD, ST_CODE, ST_SEND, ST_PULSE, ST_WAIT, ST_HALT
  } stateT;

  typedef enum logic [2:0] {
    SEL_ECHO, SEL_NAK, SEL_ERR, SEL_OK, SEL_BAD
  } ackSelT;

  typedef struct packed {
    logic   loadAck;
    ackSelT ackSel;
    logic   setMode;
    logic   codeStage;
  } ctlStrobeT;

  localparam int BYTE_W   = 8;
  localparam int NIBBLE_W = BYTE_W / 2;

endpackage

// File: rtl/boot_erase_dpath.sv
module boot_erase_dpath
  import boot_erase_pkg::*;
#(
  parameter logic [7:0] UART_CODE  = 8'h86,
  parameter logic [7:0] IO_CODE    = 8'h30,
  parameter logic [7:0] CMD_CODE   = 8'h40,
  parameter logic [7:0] ERASE_CODE = 8'h54,
  parameter logic [7:0] OK_CODE    = 8'h4F,
  parameter logic [7:0] BAD_CODE   = 8'h4C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rxData,
  input  ctlStrobeT         strobe,
  output logic              modeUart,
  output logic              rxIsUart,
  output logic              rxIsIo,
  output logic              rxIsCmd,
  output logic              rxIsErase,
  output logic [BYTE_W-1:0] txData
);

  localparam logic [NIBBLE_W-1:0] NAK_LOW = NIBBLE_W'(1);
  localparam logic [NIBBLE_W-1:0] ERR_LOW = NIBBLE_W'(8);

  logic [BYTE_W-1:0] expCode;
  logic [BYTE_W-1:0] nextAck;
  logic [BYTE_W-1:0] ackByte;

  assign rxIsUart  = (rxData == UART_CODE);
  assign rxIsIo    = (rxData == IO_CODE);
  assign rxIsCmd   = (rxData == CMD_CODE);
  assign rxIsErase = (rxData == ERASE_CODE);

  always_comb begin
    expCode = strobe.codeStage ? ERASE_CODE : CMD_CODE;
    case (strobe.ackSel)
      SEL_NAK: nextAck = {expCode[BYTE_W-1:NIBBLE_W], NAK_LOW};
      SEL_ERR: nextAck = {expCode[BYTE_W-1:NIBBLE_W], ERR_LOW};
      SEL_OK:  nextAck = OK_CODE;
      SEL_BAD: nextAck = BAD_CODE;
      default: nextAck = rxData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ackByte  <= '0;
      modeUart <= 1'b0;
    end else begin
      if (strobe.loadAck) ackByte  <= nextAck;
      if (strobe.setMode) modeUart <= rxIsUart;
    end
  end

  assign txData = ackByte;

  // R4: a negative answer carries low nibble 0x1
  a_r4_nak_low: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadAck && strobe.ackSel == SEL_NAK) |=> (ackByte[NIBBLE_W-1:0] == NAK_LOW));

  // R5: an error answer carries low nibble 0x8
  a_r5_err_low: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadAck && strobe.ackSel == SEL_ERR) |=> (ackByte[NIBBLE_W-1:0] == ERR_LOW));

endmodule

// File: rtl/boot_erase_ctrl.sv
module boot_erase_ctrl
  import boot_erase_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rxValid,
  input  logic      rxErr,
  input  logic      txBusy,
  input  logic      eraseDone,
  input  logic      eraseFail,
  input  logic      modeUart,
  input  logic      rxIsUart,
  input  logic      rxIsIo,
  input  logic      rxIsCmd,
  input  logic      rxIsErase,
  output ctlStrobeT strobe,
  output logic      txValid,
  output logic      eraseReq,
  output logic      halted
);

  stateT state, nextState;
  stateT retState, nextRet;

  always_comb begin
    nextState = state;
    nextRet   = retState;
    strobe    = '{loadAck: 1'b0, ackSel: SEL_ECHO, setMode: 1'b0, codeStage: 1'b0};
    case (state)
      ST_MODE: if (rxValid) begin
        if (rxIsUart || rxIsIo) begin
          strobe.loadAck = 1'b1;
          strobe.setMode = 1'b1;
          nextState = ST_SEND;
          nextRet   = ST_CMD;
        end else begin
          nextState = ST_HALT;
        end
      end
      ST_CMD, ST_CODE: begin
        strobe.codeStage = (state == ST_CODE);
        if (rxValid) begin
          nextRet = ST_CMD;
          if (rxErr) begin
            if (modeUart) begin
              strobe.loadAck = 1'b1;
              strobe.ackSel  = SEL_ERR;
              nextState = ST_SEND;
            end else begin
              nextState = ST_CMD;
            end
          end else if ((state == ST_CMD) ? rxIsCmd : rxIsErase) begin
            strobe.loadAck = 1'b1;
            nextState = ST_SEND;
            nextRet   = (state == ST_CMD) ? ST_CODE : ST_PULSE;
          end else begin
            strobe.loadAck = 1'b1;
            strobe.ackSel  = SEL_NAK;
            nextState = ST_SEND;
          end
        end
      end
      ST_SEND:  if (!txBusy) nextState = retState;
      ST_PULSE: nextState = ST_WAIT;
      ST_WAIT: if (eraseFail || eraseDone) begin
        strobe.loadAck = 1'b1;
        strobe.ackSel  = eraseFail ? SEL_BAD : SEL_OK;
        nextState = ST_SEND;
        nextRet   = ST_CMD;
      end
      ST_HALT: nextState = ST_HALT;
      default: nextState = ST_MODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_MODE;
      retState <= ST_CMD;
    end else begin
      state    <= nextState;
      retState <= nextRet;
    end
  end

  assign txValid  = (state == ST_SEND);
  assign eraseReq = (state == ST_PULSE);
  assign halted   = (state == ST_HALT);

  // R7: request lasts one cycle
  a_r7_req_single: assert property (@(posedge clk) disable iff (rst)
    eraseReq |=> !eraseReq);

  // R7: request only right after an acknowledge was taken
  a_r7_req_after_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(eraseReq) |-> $past(txValid && !txBusy));

  // R9: offered byte is held while the transmitter is busy
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (rst)
    (txValid && txBusy) |=> txValid);

  // R2: halt is permanent and silent
  a_r2_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !txValid));

  // R8: nothing but a result leaves the erase wait
  a_r8_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !eraseDone && !eraseFail) |=> (state == ST_WAIT));

endmodule

// File: rtl/boot_erase_responder.sv
module boot_erase_responder
  import boot_erase_pkg::*;
#(
  parameter logic [7:0] UART_CODE  = 8'h86,
  parameter logic [7:0] IO_CODE    = 8'h30,
  parameter logic [7:0] CMD_CODE   = 8'h40,
  parameter logic [7:0] ERASE_CODE = 8'h54,
  parameter logic [7:0] OK_CODE    = 8'h4F,
  parameter logic [7:0] BAD_CODE   = 8'h4C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       rxErr,
  input  logic       txBusy,
  output logic       txValid,
  output logic [7:0] txData,
  output logic       eraseReq,
  input  logic       eraseDone,
  input  logic       eraseFail,
  output logic       halted
);

  ctlStrobeT strobe;
  logic modeUart, rxIsUart, rxIsIo, rxIsCmd, rxIsErase;

  boot_erase_ctrl u_ctrl (
    .clk(clk), .rst(rst), .rxValid(rxValid), .rxErr(rxErr), .txBusy(txBusy),
    .eraseDone(eraseDone), .eraseFail(eraseFail), .modeUart(modeUart),
    .rxIsUart(rxIsUart), .rxIsIo(rxIsIo), .rxIsCmd(rxIsCmd), .rxIsErase(rxIsErase),
    .strobe(strobe), .txValid(txValid), .eraseReq(eraseReq), .halted(halted)
  );

  boot_erase_dpath #(
    .UART_CODE(UART_CODE), .IO_CODE(IO_CODE), .CMD_CODE(CMD_CODE),
    .ERASE_CODE(ERASE_CODE), .OK_CODE(OK_CODE), .BAD_CODE(BAD_CODE)
  ) u_dpath (
    .clk(clk), .rst(rst), .rxData(rxData), .strobe(strobe), .modeUart(modeUart),
    .rxIsUart(rxIsUart), .rxIsIo(rxIsIo), .rxIsCmd(rxIsCmd), .rxIsErase(rxIsErase),
    .txData(txData)
  );

endmodule

// File: tb/boot_erase_responder_bench.sv
module boot_erase_responder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic rxErr = 1'b0;
  logic txBusy = 1'b0;
  logic eraseDone = 1'b0;
  logic eraseFail = 1'b0;
  logic txValid, eraseReq, halted;
  logic [7:0] txData;

  int nChecks = 0;
  int nFail = 0;
  int reqCycles = 0;
  int holdViol = 0;
  int erasesExp = 0;
  bit busyEn = 1'b0;
  bit finished = 1'b0;
  logic [7:0] txQ[$];
  logic prevStall = 1'b0;
  logic [7:0] prevData = '0;

  always #5 clk = ~clk;

  boot_erase_responder u_boot_erase_responder (
    .clk(clk), .rst(rst), .rxValid(rxValid), .rxData(rxData), .rxErr(rxErr),
    .txBusy(txBusy), .txValid(txValid), .txData(txData), .eraseReq(eraseReq),
    .eraseDone(eraseDone), .eraseFail(eraseFail), .halted(halted)
  );

  // transmitter model and monitors
  always @(negedge clk) begin
    if (prevStall && (!txValid || txData != prevData)) holdViol++;
    txBusy = busyEn ? (($urandom % 3) == 0) : 1'b0;
    if (txValid && !txBusy) txQ.push_back(txData);
    prevStall = txValid && txBusy;
    prevData  = txData;
    if (eraseReq) reqCycles++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input logic e);
    @(negedge clk);
    rxValid = 1'b1; rxData = d; rxErr = e;
    @(negedge clk);
    rxValid = 1'b0; rxErr = 1'b0;
  endtask

  task automatic expectAck(input logic [7:0] exp, input string tag);
    int t = 0;
    while (txQ.size() == 0 && t < 60) begin
      @(negedge clk); #1; t++;
    end
    if (txQ.size() == 0) check(1'b0, tag, 'hFFF, exp);
    else begin
      check(txQ[0] == exp, tag, txQ[0], exp);
      void'(txQ.pop_front());
    end
  endtask

  task automatic expectNone(input string tag);
    repeat (20) @(negedge clk);
    #1;
    check(txQ.size() == 0, tag, txQ.size(), 0);
    txQ.delete();
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    txQ.delete();
  endtask

  // ends an erase after the 0x54 answer was taken; junk bytes arrive meanwhile
  task automatic finishErase(input bit fail, input bit both, input int junk);
    erasesExp++;
    repeat (3) @(negedge clk);
    for (int j = 0; j < junk; j++) sendByte(8'($urandom), 1'($urandom));
    @(negedge clk);
    eraseDone = !fail || both;
    eraseFail = fail;
    @(negedge clk);
    eraseDone = 1'b0; eraseFail = 1'b0;
    expectAck(fail ? 8'h4C : 8'h4F, "R8 erase result");
    check(reqCycles == erasesExp, "R7 request pulses", reqCycles, erasesExp);
  endtask

  // expected answer: bit 8 = answer present
  function automatic logic [8:0] modelAck(bit stage, logic [7:0] d, bit e, bit uart);
    logic [7:0] expc = stage ? 8'h54 : 8'h40;
    if (e) return uart ? {1'b1, expc[7:4], 4'h8} : 9'h000;
    if (d == expc) return {1'b1, expc};
    return {1'b1, expc[7:4], 4'h1};
  endfunction

  task automatic randomRun(input bit uart, input int n);
    bit stage = 1'b0;
    for (int i = 0; i < n; i++) begin
      int kind = $urandom % 4;
      logic [7:0] expc = stage ? 8'h54 : 8'h40;
      logic [7:0] d = expc;
      bit e = 1'b0;
      logic [8:0] m;
      if (kind == 2) begin
        d = 8'($urandom);
        while (d == expc) d = 8'($urandom);
      end else if (kind == 3) begin
        d = 8'($urandom); e = 1'b1;
      end
      m = modelAck(stage, d, e, uart);
      sendByte(d, e);
      if (m[8]) expectAck(m[7:0], uart ? "R3/R4/R5 random uart" : "R3/R4 random io");
      else expectNone("R6 random io error");
      if (!e && d == expc && stage) begin
        finishErase(1'($urandom), 1'($urandom), $urandom % 3);
        stage = 1'b0;
      end else stage = (!e && d == expc) ? 1'b1 : 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    doReset();
    @(negedge clk); #1;
    check(!txValid && !eraseReq && !halted, "R10 reset outputs",
          {txValid, eraseReq, halted}, 0);

    // unknown mode byte
    sendByte(8'h55, 1'b0);
    expectNone("R2 no ack on bad mode");
    check(halted == 1'b1, "R2 halted", halted, 1);
    sendByte(8'h86, 1'b0);
    expectNone("R2 later byte ignored");
    check(halted == 1'b1, "R2 still halted", halted, 1);

    // UART mode directed
    doReset();
    busyEn = 1'b1;
    sendByte(8'h86, 1'b0); expectAck(8'h86, "R1 uart echo");
    sendByte(8'h40, 1'b0); expectAck(8'h40, "R3 cmd ack");
    sendByte(8'h54, 1'b0); expectAck(8'h54, "R3 erase code ack");
    finishErase(1'b0, 1'b0, 2);
    sendByte(8'h22, 1'b0); expectAck(8'h41, "R4 nak step one");
    sendByte(8'h40, 1'b0); expectAck(8'h40, "R3 cmd ack");
    sendByte(8'h99, 1'b0); expectAck(8'h51, "R4 nak step two");
    sendByte(8'h54, 1'b0); expectAck(8'h41, "R4 back to wait cmd");
    sendByte(8'h40, 1'b1); expectAck(8'h48, "R5 error step one");
    sendByte(8'h40, 1'b0); expectAck(8'h40, "R3 cmd ack");
    sendByte(8'h54, 1'b1); expectAck(8'h58, "R5 error step two");
    sendByte(8'h40, 1'b0); expectAck(8'h40, "R5 resumed at cmd");
    sendByte(8'h54, 1'b0); expectAck(8'h54, "R3 erase code ack");
    finishErase(1'b1, 1'b1, 3);
    expectNone("R9 single byte per answer");
    randomRun(1'b1, 120);

    // I/O mode
    doReset();
    sendByte(8'h30, 1'b0); expectAck(8'h30, "R1 io echo");
    sendByte(8'h40, 1'b1); expectNone("R6 silent error step one");
    sendByte(8'h40, 1'b0); expectAck(8'h40, "R6 cmd after error");
    sendByte(8'h54, 1'b1); expectNone("R6 silent error step two");
    sendByte(8'h54, 1'b0); expectAck(8'h41, "R6 back to wait cmd");
    randomRun(1'b0, 120);

    check(holdViol == 0, "R9 hold while busy", holdViol, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule